// File: doc/BRIEF.md
# Virtual-Function Doorbell Mailbox

This block holds the doorbell registers through which one host-side physical function (PF) exchanges short messages with `VF_COUNT` virtual functions (VFs). The PF port can reach the register set of any VF slot. Each VF has its own port, and that port reaches only the registers of its own slot. The block drives an interrupt toward the receiver of a message while the message's interrupt bit is high. The receiver acknowledges the message by writing that bit low, and the interrupt drops.

The elaboration parameter `SPLIT_MODE` selects one of two layouts. With `SPLIT_MODE = 0` (shared), each slot has a single 32-bit word. Its low half (bits 15:0) carries PF-to-VF traffic, with the interrupt on bit 0. Its high half (bits 31:16) carries VF-to-PF traffic, with the interrupt on bit 16. A sender may first write an in-use marker into the opposite half, so every write is byte-enabled and a write to one half leaves the other half untouched. With `SPLIT_MODE = 1` (split), each slot has two words. Word select 0 is the PF-to-VF word and word select 1 is the VF-to-PF word, and in both words bit 0 is the interrupt. In every message half or word, the bit directly above the interrupt bit marks a valid system message. The block stores that bit like any other data bit.

On the PF side, a per-slot status vector shows which VFs have a message pending toward the PF, and a single PF interrupt is the OR of that vector. An asynchronous reset assertion is released through a two-stage synchronizer.

Top module: `pfvf_mbox`

## Requirements
- R1: While reset is held and after it is released, before any write, every register reads zero and every interrupt output and status bit is low.
- R2: Shared mode: a PF write that sets bit 0 of slot i's word raises `vf_irq[i]` on the cycle after the write edge, and no other VF interrupt changes.
- R3: Shared mode: a write by VF i that sets bit 16 raises `pf_irq_status[i]` on the cycle after the write edge.
- R4: Writing 0 to the interrupt bit of the register that carried the message deasserts the matching interrupt on the cycle after the write edge.
- R5: Byte enable bit b gates data bits 8b+7:8b. Bytes whose enable is low keep their old value, so a write to one 16-bit half never alters the other half.
- R6: When the PF port and the VF port of one slot write the same word in the same cycle, each byte enabled by only one port takes that port's data, and each byte enabled by both ports takes the PF data.
- R7: A write on the port of VF j never changes any register of a slot other than j.
- R8: Split mode: word select 0 is the PF-to-VF word and its bit 0 drives `vf_irq[i]`. Word select 1 is the VF-to-PF word and its bit 0 drives `pf_irq_status[i]`. A write to one word leaves the other word unchanged.
- R9: Shared mode: writes with word select 1 are ignored, and reads with word select 1 return zero.
- R10: `pf_irq` is high exactly when at least one bit of `pf_irq_status` is high.
- R11: The origin flag (bit 1, and bit 17 in shared mode) is stored and read back, and setting it alone raises no interrupt.
- R12: `pf_rdata` shows, in the same cycle, the register addressed by `pf_idx`/`pf_sel`. `vf_rdata` slice i shows slot i's register selected by `vf_sel[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pf_we | input | 1 | PF write strobe |
| pf_idx | input | IDX_W | VF slot addressed by the PF |
| pf_sel | input | 1 | PF word select (0 = toward VF, 1 = toward PF) |
| pf_be | input | 4 | PF byte enables |
| pf_wdata | input | 32 | PF write data |
| pf_rdata | output | 32 | Addressed register, combinational |
| pf_irq | output | 1 | Interrupt to the PF: OR of the status vector |
| pf_irq_status | output | VF_COUNT | Per-slot pending VF-to-PF message |
| vf_we | input | VF_COUNT | Per-VF write strobe |
| vf_sel | input | VF_COUNT | Per-VF word select |
| vf_be | input | 4*VF_COUNT | Per-VF byte enables |
| vf_wdata | input | 32*VF_COUNT | Per-VF write data |
| vf_rdata | output | 32*VF_COUNT | Per-VF read data of its own slot |
| vf_irq | output | VF_COUNT | Per-VF interrupt for a pending PF-to-VF message |

## Verification
A corrupted slot register appears at once on the combinational read ports. Every cycle the bench compares it against a reference model on all VF read slices and on the PF read port. A wrong write merge or a wrong lane choice in a collision therefore appears on the cycle after the faulty write. Interrupt and status errors show on the same cycle as the register bits behind them. Random traffic with colliding PF and VF writes runs in both layouts, next to directed raise, acknowledge, marker and isolation cases.

// File: rtl/pfvf_mbox_pkg.sv
package pfvf_mbox_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int TO_VF_INT = 0;
  localparam int TO_PF_INT_SHARED = 16;

  // byte-lane merge: host lane beats function lane when both enable it
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] cur,
    input logic              a_hit,
    input logic [LANES-1:0]  a_be,
    input logic [WORD_W-1:0] a_data,
    input logic              b_hit,
    input logic [LANES-1:0]  b_be,
    input logic [WORD_W-1:0] b_data
  );
    logic [WORD_W-1:0] res;
    res = cur;
    for (int l = 0; l < LANES; l++) begin
      if (a_hit && a_be[l])      res[l*8 +: 8] = a_data[l*8 +: 8];
      else if (b_hit && b_be[l]) res[l*8 +: 8] = b_data[l*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/pfvf_mbox_slot.sv
module pfvf_mbox_slot
  import pfvf_mbox_pkg::*;
#(
  parameter bit SPLIT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_we,
  input  logic              pf_sel,
  input  logic [LANES-1:0]  pf_be,
  input  logic [WORD_W-1:0] pf_wdata,
  input  logic              vf_we,
  input  logic              vf_sel,
  input  logic [LANES-1:0]  vf_be,
  input  logic [WORD_W-1:0] vf_wdata,
  output logic [WORD_W-1:0] down_word,
  output logic [WORD_W-1:0] up_word,
  output logic              irq_to_vf,
  output logic              irq_to_pf
);
  logic [WORD_W-1:0] w0_q, w0_d;
  logic              w0_en, pf_hit0, vf_hit0;

  assign pf_hit0 = pf_we & ~pf_sel;
  assign vf_hit0 = vf_we & ~vf_sel;

  always_comb begin
    w0_en = pf_hit0 | vf_hit0;
    w0_d  = lane_merge(w0_q, pf_hit0, pf_be, pf_wdata, vf_hit0, vf_be, vf_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     w0_q <= '0;
    else if (w0_en) w0_q <= w0_d;
  end

  assign down_word = w0_q;
  assign irq_to_vf = w0_q[TO_VF_INT];

  generate
    if (SPLIT_MODE) begin : g_split
      logic [WORD_W-1:0] w1_q, w1_d;
      logic              w1_en, pf_hit1, vf_hit1;
      assign pf_hit1 = pf_we & pf_sel;
      assign vf_hit1 = vf_we & vf_sel;
      always_comb begin
        w1_en = pf_hit1 | vf_hit1;
        w1_d  = lane_merge(w1_q, pf_hit1, pf_be, pf_wdata, vf_hit1, vf_be, vf_wdata);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     w1_q <= '0;
        else if (w1_en) w1_q <= w1_d;
      end
      assign up_word   = w1_q;
      assign irq_to_pf = w1_q[0];

      // R8
      up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((pf_we && pf_sel) || (vf_we && vf_sel)) |=> $stable(up_word));
    end else begin : g_shared
      assign up_word   = '0;
      assign irq_to_pf = w0_q[TO_PF_INT_SHARED];
    end
  endgenerate

  // R5
  down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((pf_we && !pf_sel) || (vf_we && !vf_sel)) |=> $stable(down_word));

  // R2
  pf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_we && !pf_sel && pf_be[0] && pf_wdata[0]) |=> irq_to_vf);

  // R4
  vf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_we && !vf_sel && vf_be[0] && !vf_wdata[0] && !(pf_we && !pf_sel && pf_be[0]))
    |=> !irq_to_vf);

  // R6
  pf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_we && vf_we && !pf_sel && !vf_sel && pf_be[1] && vf_be[1])
    |=> (down_word[15:8] == $past(pf_wdata[15:8])));
endmodule

// File: rtl/pfvf_mbox_irq_agg.sv
module pfvf_mbox_irq_agg #(
  parameter int VF_COUNT = 16
) (
  input  logic [VF_COUNT-1:0] pend,
  output logic [VF_COUNT-1:0] status,
  output logic                irq
);
  assign status = pend;
  assign irq    = |pend;
endmodule

// File: rtl/pfvf_mbox.sv
module pfvf_mbox
  import pfvf_mbox_pkg::*;
#(
  parameter int VF_COUNT   = 16,
  parameter bit SPLIT_MODE = 1'b0,
  localparam int IDX_W = (VF_COUNT > 1) ? $clog2(VF_COUNT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pf_we,
  input  logic [IDX_W-1:0]           pf_idx,
  input  logic                       pf_sel,
  input  logic [LANES-1:0]           pf_be,
  input  logic [WORD_W-1:0]          pf_wdata,
  output logic [WORD_W-1:0]          pf_rdata,
  output logic                       pf_irq,
  output logic [VF_COUNT-1:0]        pf_irq_status,
  input  logic [VF_COUNT-1:0]        vf_we,
  input  logic [VF_COUNT-1:0]        vf_sel,
  input  logic [VF_COUNT*LANES-1:0]  vf_be,
  input  logic [VF_COUNT*WORD_W-1:0] vf_wdata,
  output logic [VF_COUNT*WORD_W-1:0] vf_rdata,
  output logic [VF_COUNT-1:0]        vf_irq
);
  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [WORD_W-1:0]   down_w [VF_COUNT];
  logic [WORD_W-1:0]   up_w   [VF_COUNT];
  logic [VF_COUNT-1:0] pend_to_pf;

  for (genvar i = 0; i < VF_COUNT; i++) begin : g_slot
    logic pf_we_i;
    assign pf_we_i = pf_we && (pf_idx == IDX_W'(i));

    pfvf_mbox_slot #(.SPLIT_MODE(SPLIT_MODE)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .pf_we    (pf_we_i),
      .pf_sel   (pf_sel),
      .pf_be    (pf_be),
      .pf_wdata (pf_wdata),
      .vf_we    (vf_we[i]),
      .vf_sel   (vf_sel[i]),
      .vf_be    (vf_be[i*LANES +: LANES]),
      .vf_wdata (vf_wdata[i*WORD_W +: WORD_W]),
      .down_word(down_w[i]),
      .up_word  (up_w[i]),
      .irq_to_vf(vf_irq[i]),
      .irq_to_pf(pend_to_pf[i])
    );

    assign vf_rdata[i*WORD_W +: WORD_W] = vf_sel[i] ? up_w[i] : down_w[i];

    // R7
    iso_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !(pf_we_i || vf_we[i]) |=> ($stable(down_w[i]) && $stable(up_w[i])));
  end

  always_comb begin
    pf_rdata = '0;
    for (int k = 0; k < VF_COUNT; k++) begin
      if (pf_idx == IDX_W'(k)) pf_rdata = pf_sel ? up_w[k] : down_w[k];
    end
  end

  pfvf_mbox_irq_agg #(.VF_COUNT(VF_COUNT)) u_agg (
    .pend  (pend_to_pf),
    .status(pf_irq_status),
    .irq   (pf_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |=> (vf_irq == '0 && !pf_irq) || !$past(rst_n));
endmodule

// File: tb/pfvf_mbox_tb.sv
`timescale 1ns/1ps
module pfvf_mbox_tb;
  localparam int N  = 16;
  localparam int NS = 4;
  localparam int IW  = 4;
  localparam int IWS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // shared-layout instance
  logic          a_pf_we, a_pf_sel;
  logic [IW-1:0] a_pf_idx;
  logic [3:0]    a_pf_be;
  logic [31:0]   a_pf_wdata, a_pf_rdata;
  logic          a_pf_irq;
  logic [N-1:0]  a_status, a_vf_we, a_vf_sel, a_vf_irq;
  logic [N*4-1:0]  a_vf_be;
  logic [N*32-1:0] a_vf_wdata, a_vf_rdata;

  // split-layout instance
  logic           b_pf_we, b_pf_sel;
  logic [IWS-1:0] b_pf_idx;
  logic [3:0]     b_pf_be;
  logic [31:0]    b_pf_wdata, b_pf_rdata;
  logic           b_pf_irq;
  logic [NS-1:0]  b_status, b_vf_we, b_vf_sel, b_vf_irq;
  logic [NS*4-1:0]  b_vf_be;
  logic [NS*32-1:0] b_vf_wdata, b_vf_rdata;

  pfvf_mbox #(.VF_COUNT(N), .SPLIT_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pf_we(a_pf_we), .pf_idx(a_pf_idx), .pf_sel(a_pf_sel),
    .pf_be(a_pf_be), .pf_wdata(a_pf_wdata), .pf_rdata(a_pf_rdata), .pf_irq(a_pf_irq),
    .pf_irq_status(a_status), .vf_we(a_vf_we), .vf_sel(a_vf_sel), .vf_be(a_vf_be),
    .vf_wdata(a_vf_wdata), .vf_rdata(a_vf_rdata), .vf_irq(a_vf_irq));

  pfvf_mbox #(.VF_COUNT(NS), .SPLIT_MODE(1'b1)) u_dut_split (
    .clk(clk), .rst_n(rst_n), .pf_we(b_pf_we), .pf_idx(b_pf_idx), .pf_sel(b_pf_sel),
    .pf_be(b_pf_be), .pf_wdata(b_pf_wdata), .pf_rdata(b_pf_rdata), .pf_irq(b_pf_irq),
    .pf_irq_status(b_status), .vf_we(b_vf_we), .vf_sel(b_vf_sel), .vf_be(b_vf_be),
    .vf_wdata(b_vf_wdata), .vf_rdata(b_vf_rdata), .vf_irq(b_vf_irq));

  logic [31:0] ma  [N];
  logic [31:0] mb0 [NS];
  logic [31:0] mb1 [NS];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] ref_merge(logic [31:0] cur, logic ph, logic [3:0] pbe,
      logic [31:0] pd, logic vh, logic [3:0] vbe, logic [31:0] vd);
    logic [31:0] r = cur;
    for (int l = 0; l < 4; l++) begin
      if (ph && pbe[l])      r[l*8 +: 8] = pd[l*8 +: 8];
      else if (vh && vbe[l]) r[l*8 +: 8] = vd[l*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic any;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      chk(a_vf_sel[i] ? "R9 vf read" : "R12 vf read", a_vf_rdata[i*32 +: 32],
          a_vf_sel[i] ? 32'h0 : ma[i]);
      chk("R2 vf irq", {31'b0, a_vf_irq[i]}, {31'b0, ma[i][0]});
      chk("R3 pf status", {31'b0, a_status[i]}, {31'b0, ma[i][16]});
      any |= ma[i][16];
    end
    chk("R10 pf irq", {31'b0, a_pf_irq}, {31'b0, any});
    chk("R12 pf read", a_pf_rdata, a_pf_sel ? 32'h0 : ma[a_pf_idx]);
    any = 1'b0;
    for (int i = 0; i < NS; i++) begin
      chk("R8 vf read", b_vf_rdata[i*32 +: 32], b_vf_sel[i] ? mb1[i] : mb0[i]);
      chk("R8 vf irq", {31'b0, b_vf_irq[i]}, {31'b0, mb0[i][0]});
      chk("R8 pf status", {31'b0, b_status[i]}, {31'b0, mb1[i][0]});
      any |= mb1[i][0];
    end
    chk("R10 split pf irq", {31'b0, b_pf_irq}, {31'b0, any});
    chk("R12 split pf read", b_pf_rdata, b_pf_sel ? mb1[b_pf_idx] : mb0[b_pf_idx]);
  endtask

  task automatic apply_models();
    for (int i = 0; i < N; i++)
      ma[i] = ref_merge(ma[i], a_pf_we && a_pf_idx == IW'(i) && !a_pf_sel, a_pf_be, a_pf_wdata,
                        a_vf_we[i] && !a_vf_sel[i], a_vf_be[i*4 +: 4], a_vf_wdata[i*32 +: 32]);
    for (int i = 0; i < NS; i++) begin
      mb0[i] = ref_merge(mb0[i], b_pf_we && b_pf_idx == IWS'(i) && !b_pf_sel, b_pf_be, b_pf_wdata,
                         b_vf_we[i] && !b_vf_sel[i], b_vf_be[i*4 +: 4], b_vf_wdata[i*32 +: 32]);
      mb1[i] = ref_merge(mb1[i], b_pf_we && b_pf_idx == IWS'(i) && b_pf_sel, b_pf_be, b_pf_wdata,
                         b_vf_we[i] && b_vf_sel[i], b_vf_be[i*4 +: 4], b_vf_wdata[i*32 +: 32]);
    end
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    apply_models();
    @(negedge clk);
  endtask

  task automatic idle();
    a_pf_we = 0; a_vf_we = '0; a_vf_sel = '0; a_pf_sel = 0;
    b_pf_we = 0; b_vf_we = '0; b_vf_sel = '0; b_pf_sel = 0;
  endtask

  task automatic a_pf(int idx, logic [3:0] be, logic [31:0] d);
    a_pf_we = 1; a_pf_idx = IW'(idx); a_pf_sel = 0; a_pf_be = be; a_pf_wdata = d;
  endtask

  task automatic a_vf(int i, logic sel, logic [3:0] be, logic [31:0] d);
    a_vf_we[i] = 1; a_vf_sel[i] = sel; a_vf_be[i*4 +: 4] = be; a_vf_wdata[i*32 +: 32] = d;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    for (int i = 0; i < N; i++)  ma[i] = '0;
    for (int i = 0; i < NS; i++) begin mb0[i] = '0; mb1[i] = '0; end
    idle();
    a_pf_idx = '0; a_pf_be = '0; a_pf_wdata = '0; a_vf_be = '0; a_vf_wdata = '0;
    b_pf_idx = '0; b_pf_be = '0; b_pf_wdata = '0; b_vf_be = '0; b_vf_wdata = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 irq in reset", {31'b0, a_pf_irq}, 32'h0);
    chk("R1 vf irq in reset", {16'b0, a_vf_irq}, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1 chk("R1 read after reset", a_pf_rdata, 32'h0);
    step();

    // R2 raise toward VF 3, R11 origin-only on VF 5
    a_pf(3, 4'b0001, 32'h0000_0003); step();
    idle(); a_pf(5, 4'b0001, 32'h0000_0002); step();
    idle(); step();
    chk("R2 vf3 raised", {31'b0, a_vf_irq[3]}, 32'h1);
    chk("R11 origin stored", a_vf_rdata[5*32 +: 32], 32'h0000_0002);
    chk("R11 origin alone no irq", {31'b0, a_vf_irq[5]}, 32'h0);

    // R3 VF 7 raises toward PF, then R5 PF writes an in-use marker in the low half
    a_vf(7, 0, 4'b0100, 32'h0003_0000); step();
    idle(); a_pf(7, 4'b0011, 32'hFFFF_ABCD); step();
    idle(); step();
    chk("R3 status 7", {31'b0, a_status[7]}, 32'h1);
    chk("R5 half write keeps other half", a_vf_rdata[7*32 +: 32], 32'h0003_ABCD);

    // R4 acknowledges on both directions
    a_pf(7, 4'b0100, 32'h0); a_vf(3, 0, 4'b0001, 32'h0); step();
    idle(); step();
    chk("R4 pf ack clears status", {31'b0, a_status[7]}, 32'h0);
    chk("R4 vf ack clears irq", {31'b0, a_vf_irq[3]}, 32'h0);
    chk("R4 pf irq low", {31'b0, a_pf_irq}, 32'h0);

    // R6 overlapping then disjoint collisions on slot 2
    a_pf(2, 4'b1111, 32'h1111_1111); a_vf(2, 0, 4'b0110, 32'h2222_2222); step();
    idle(); step();
    chk("R6 overlap pf wins", a_vf_rdata[2*32 +: 32], 32'h1111_1111);
    a_pf(2, 4'b0011, 32'h0000_AAAA); a_vf(2, 0, 4'b1100, 32'h5555_0000); step();
    idle(); step();
    chk("R6 disjoint lanes merge", a_vf_rdata[2*32 +: 32], 32'h5555_AAAA);

    // R9 word select 1 ignored in shared layout; R7 VF 0 write does not reach slot 1
    a_vf(4, 1, 4'b1111, 32'hFFFF_FFFF); a_vf(0, 0, 4'b1111, 32'h0001_0001); step();
    idle(); a_vf_sel[4] = 1; step();
    chk("R9 sel1 reads zero", a_vf_rdata[4*32 +: 32], 32'h0);
    a_vf_sel[4] = 0; step();
    chk("R9 sel1 write ignored", a_vf_rdata[4*32 +: 32], 32'h0);
    a_pf_idx = 1; a_pf_sel = 0; step();
    chk("R7 slot 1 untouched", a_pf_rdata, 32'h0);

    // R8 split layout
    b_pf_we = 1; b_pf_idx = 1; b_pf_sel = 0; b_pf_be = 4'hF; b_pf_wdata = 32'h0000_0003; step();
    idle(); b_vf_we[1] = 1; b_vf_sel[1] = 1; b_vf_be[4 +: 4] = 4'hF; b_vf_wdata[32 +: 32] = 32'h0000_0003; step();
    idle(); step();
    chk("R8 down word irq", {31'b0, b_vf_irq[1]}, 32'h1);
    chk("R8 up word status", {31'b0, b_status[1]}, 32'h1);
    chk("R8 down word unchanged", b_vf_rdata[32 +: 32], 32'h0000_0003);

    // constrained random traffic on both layouts
    for (int c = 0; c < 3000; c++) begin
      idle();
      a_pf_we = ($urandom_range(0, 9) < 3); a_pf_idx = IW'($urandom);
      a_pf_sel = ($urandom_range(0, 9) == 0); a_pf_be = 4'($urandom); a_pf_wdata = $urandom;
      b_pf_we = ($urandom_range(0, 9) < 3); b_pf_idx = IWS'($urandom);
      b_pf_sel = 1'($urandom); b_pf_be = 4'($urandom); b_pf_wdata = $urandom;
      for (int i = 0; i < N; i++) begin
        a_vf_we[i] = ($urandom_range(0, 9) == 0);
        a_vf_sel[i] = ($urandom_range(0, 9) == 0);
        a_vf_be[i*4 +: 4] = 4'($urandom); a_vf_wdata[i*32 +: 32] = $urandom;
      end
      for (int i = 0; i < NS; i++) begin
        b_vf_we[i] = ($urandom_range(0, 4) == 0); b_vf_sel[i] = 1'($urandom);
        b_vf_be[i*4 +: 4] = 4'($urandom); b_vf_wdata[i*32 +: 32] = $urandom;
      end
      step();
    end
    idle(); step(); step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule